// File: doc/BRIEF.md
# Two-Wire Bus Control and Status Register Set

This block holds the registers that software uses to drive a two-wire serial bus controller. Software reaches it over a small register port: read enable, write enable, a register select, write data and read data. There are three registers. The control register carries the enable, interrupt-enable, stop-request, collision and event-flag bits. The status register merges a bus-state code from the engine with a software prescaler field. The data register refuses writes while the event flag is low.

The bus engine itself sits outside this block. It reports a 5-bit state code, a pulse when a requested STOP has been put on the bus, a one-cycle event that raises the flag, and whether it is acting as master. In return it gets a stop request, an enable, a one-cycle slave recovery pulse, the data byte and the decoded bit-rate divider. An interrupt request combines the flag, the interrupt enable and a global interrupt gate.

Top module: `twb_csr`

## Requirements
- R1: Register select 0 is control, 1 is status, 2 is data and 3 reads as 0. The read data is combinational from the current state while the read enable is high, and 0 otherwise. A write takes effect at the clock edge on which the write enable is sampled.
- R2: A control write with bit 2 = 1 and bit 0 = 1 while the master input is 1 raises stop_req in the next cycle. stop_req stays high until the edge on which the stop-done pulse is sampled, and drops on that edge. If a setting write lands in the same cycle as the stop-done pulse, the write wins. Control bit 2 reads back the stop request.
- R3: The same control write made while the master input is 0 leaves stop_req low. It drives slave_recover high for exactly the one cycle after the write.
- R4: A data write while the flag is 1 stores the byte, which is then visible on data_out and at select 2. It also clears the collision bit (control bit 3).
- R5: A data write while the flag is 0 leaves the data unchanged and sets the collision bit, which stays set until a data write is accepted. A write in the same cycle as the flag-set event counts as a write with the flag low.
- R6: A control write with bit 0 = 0 drops if_enable and clears any pending stop request from the next cycle, whatever the other bits hold.
- R7: The flag (control bit 7) is set by the flag-set event and is cleared by a control write with bit 7 = 1. The event wins if both happen in the same cycle. irq is high exactly while the flag, the interrupt enable (control bit 1) and glb_irq_en are all 1.
- R8: The prescaler field decodes 00 to a divider of 1, 01 to 4, 10 to 16 and 11 to 64, driven on prescale_div.
- R9: The status read is {state code, 0, prescaler}, with bits 7:3 the engine code as registered one cycle earlier, bit 2 = 0 and bits 1:0 the prescaler. A status write changes only bits 1:0.
- R10: After reset the status reads 0xF8, control and data read 0x00, every output is low except prescale_div, and prescale_div is 1.
- R11: Control bits 6:4 always read 0, and writes to them are ignored. The collision bit cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read enable |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| eng_status | input | 5 | Bus-state code from engine |
| eng_is_master | input | 1 | Engine is in master mode |
| eng_stop_done | input | 1 | Requested STOP has been issued |
| eng_flag_set | input | 1 | One-cycle event that raises the flag |
| glb_irq_en | input | 1 | Global interrupt gate |
| stop_req | output | 1 | STOP request to engine |
| if_enable | output | 1 | Interface enable to engine |
| slave_recover | output | 1 | One-cycle return-to-idle-slave pulse |
| irq | output | 1 | Interrupt request |
| data_out | output | 8 | Data register contents |
| prescale_div | output | 7 | Decoded bit-rate divider |

## Verification
Every register effect (stop_req, if_enable, slave_recover, flag, collision, data, prescaler) appears in the cycle after the write or event is sampled. The state code shows up in the status read one cycle after it is presented. irq and rdata follow their inputs in the same cycle. The bench drives its inputs just after each rising edge and advances a behavioural model on the same edge. It compares every output and the read data on the falling edge, so each comparison sees the value due in that cycle. Directed checks on the edge cases (stop done against a setting write, a write on the flag-set edge, disable while a stop is pending) sample in the same way, right after the edge that applies them.

// File: rtl/twb_pkg.sv
// Shared constants for the two-wire bus register set.
// Assumes an 8-bit register word made of a 5-bit code, one spare bit and a 2-bit prescaler.
package twb_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned CODE_W = 5;
    localparam int unsigned PS_W   = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int unsigned B_EN   = 0;
    localparam int unsigned B_IE   = 1;
    localparam int unsigned B_STOP = 2;
    localparam int unsigned B_COLL = 3;
    localparam int unsigned B_FLAG = 7;
endpackage

// File: rtl/twb_ctrl_reg.sv
// Control bits: enable, interrupt enable, stop request, event flag and slave recovery pulse.
// Assumes the engine's done and flag-set inputs are single-cycle pulses synchronous to clk.
module twb_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic w_en,
    input  logic w_ie,
    input  logic w_stop,
    input  logic w_flag,
    input  logic eng_is_master,
    input  logic eng_stop_done,
    input  logic eng_flag_set,
    output logic en_q,
    output logic ie_q,
    output logic stop_q,
    output logic flag_q,
    output logic recover_q
);
    logic stop_ask;
    assign stop_ask = wr && w_en && w_stop;

    // enable and interrupt-enable follow control writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ie_q <= 1'b0;
        end else if (wr) begin
            en_q <= w_en;
            ie_q <= w_ie;
        end
    end

    // stop request: set by a master-mode ask, cleared by done or by disable
    always_ff @(posedge clk) begin
        if (!rst_n)                       stop_q <= 1'b0;
        else if (wr && !w_en)             stop_q <= 1'b0;
        else if (stop_ask && eng_is_master) stop_q <= 1'b1;
        else if (eng_stop_done)           stop_q <= 1'b0;
    end

    // one-cycle recovery pulse for a stop ask in slave mode
    always_ff @(posedge clk) begin
        if (!rst_n) recover_q <= 1'b0;
        else        recover_q <= stop_ask && !eng_is_master;
    end

    // event flag: engine event sets it, a write of one clears it, the event wins
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (eng_flag_set)   flag_q <= 1'b1;
        else if (wr && w_flag)   flag_q <= 1'b0;
    end

    // R2
    stop_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && eng_stop_done && !stop_ask) |=> !stop_q);
    // R3
    slave_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ask && !eng_is_master && !stop_q) |=> (recover_q && !stop_q));
    // R6
    disable_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !w_en) |=> (!en_q && !stop_q));
    // R7
    flag_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_flag_set |=> flag_q);
endmodule

// File: rtl/twb_data_reg.sv
// Data register with write-collision guard: a write is accepted only while the flag is high.
// Assumes flag is the registered flag; a same-cycle set event does not admit the write.
module twb_data_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic [DATA_W-1:0] data_q,
    output logic              coll_q
);
    // store the byte when allowed, else keep it and mark a collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            coll_q <= 1'b0;
        end else if (wr) begin
            if (flag) begin
                data_q <= wdata;
                coll_q <= 1'b0;
            end else begin
                coll_q <= 1'b1;
            end
        end
    end

    // R5
    collision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !flag) |=> (coll_q && data_q == $past(data_q)));
    // R4
    accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && flag) |=> (!coll_q && data_q == $past(wdata)));
endmodule

// File: rtl/twb_status_reg.sv
// Status word: registered engine code merged with a software prescaler, plus divider decode.
// Assumes the divider output is one-hot with a stride of two bit positions per code.
module twb_status_reg #(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned PS_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [PS_W-1:0]            w_ps,
    input  logic [CODE_W-1:0]          eng_status,
    output logic [CODE_W+PS_W:0]       status_word,
    output logic [2*((1<<PS_W)-1):0]   div
);
    localparam int unsigned NCODES = 1 << PS_W;
    localparam int unsigned DIV_W  = 2*(NCODES-1)+1;

    logic [CODE_W-1:0] code_q;
    logic [PS_W-1:0]   ps_q;

    // capture the engine code each cycle; reset value is all ones
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '1;
        else        code_q <= eng_status;
    end

    // prescaler is the only writable part of the status word
    always_ff @(posedge clk) begin
        if (!rst_n)  ps_q <= '0;
        else if (wr) ps_q <= w_ps;
    end

    assign status_word = {code_q, 1'b0, ps_q};

    // one-hot divider: code k lights bit 2k
    generate
        for (genvar k = 0; k < NCODES; k++) begin : g_div
            assign div[2*k] = (ps_q == k[PS_W-1:0]);
            if (k < NCODES-1) begin : g_gap
                assign div[2*k+1] = 1'b0;
            end
        end
    endgenerate

    // R8
    div_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(div) == 1);
    // R9
    code_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_word[CODE_W+PS_W:PS_W+1] == $past(eng_status));
    // R9
    ps_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> div[DIV_W-1:0] == ({{(DIV_W-1){1'b0}},1'b1} << (2*$past(w_ps))));
endmodule

// File: rtl/twb_csr.sv
// Top of the two-wire bus register set: address decode, read mux and interrupt request.
// Assumes one register access per cycle; reads have no side effects.
module twb_csr #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned CODE_W = twb_pkg::CODE_W,
    parameter int unsigned PS_W   = twb_pkg::PS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CODE_W+PS_W:0]          wdata,
    output logic [CODE_W+PS_W:0]          rdata,
    input  logic [CODE_W-1:0]             eng_status,
    input  logic                          eng_is_master,
    input  logic                          eng_stop_done,
    input  logic                          eng_flag_set,
    input  logic                          glb_irq_en,
    output logic                          stop_req,
    output logic                          if_enable,
    output logic                          slave_recover,
    output logic                          irq,
    output logic [CODE_W+PS_W:0]          data_out,
    output logic [2*((1<<PS_W)-1):0]      prescale_div
);
    import twb_pkg::*;

    localparam int unsigned W = CODE_W + PS_W + 1;

    logic wr_ctrl, wr_stat, wr_data;
    logic en_q, ie_q, stop_q, flag_q, rec_q, coll_q;
    logic [W-1:0] stat_word, data_q, ctrl_word;

    // write strobes per register
    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(SEL_CTRL));
        wr_stat = wr_en && (addr == ADDR_W'(SEL_STAT));
        wr_data = wr_en && (addr == ADDR_W'(SEL_DATA));
    end

    twb_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(wr_ctrl),
        .w_en(wdata[B_EN]), .w_ie(wdata[B_IE]), .w_stop(wdata[B_STOP]), .w_flag(wdata[B_FLAG]),
        .eng_is_master(eng_is_master), .eng_stop_done(eng_stop_done), .eng_flag_set(eng_flag_set),
        .en_q(en_q), .ie_q(ie_q), .stop_q(stop_q), .flag_q(flag_q), .recover_q(rec_q)
    );

    twb_data_reg #(.DATA_W(W)) u_data (
        .clk(clk), .rst_n(rst_n), .wr(wr_data), .wdata(wdata), .flag(flag_q),
        .data_q(data_q), .coll_q(coll_q)
    );

    twb_status_reg #(.CODE_W(CODE_W), .PS_W(PS_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr(wr_stat), .w_ps(wdata[PS_W-1:0]),
        .eng_status(eng_status), .status_word(stat_word), .div(prescale_div)
    );

    // assemble control read word; spare bits are zero
    always_comb begin
        ctrl_word         = '0;
        ctrl_word[B_EN]   = en_q;
        ctrl_word[B_IE]   = ie_q;
        ctrl_word[B_STOP] = stop_q;
        ctrl_word[B_COLL] = coll_q;
        ctrl_word[B_FLAG] = flag_q;
    end

    // read mux, gated by the read enable
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(SEL_CTRL): rdata = ctrl_word;
                ADDR_W'(SEL_STAT): rdata = stat_word;
                ADDR_W'(SEL_DATA): rdata = data_q;
                default:           rdata = '0;
            endcase
        end
    end

    assign stop_req      = stop_q;
    assign if_enable     = en_q;
    assign slave_recover = rec_q;
    assign data_out      = data_q;
    assign irq           = flag_q && ie_q && glb_irq_en;

    // R7
    irq_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_flag_set && ie_q && !wr_ctrl) |=> (irq == glb_irq_en));
    // R11
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(SEL_CTRL)) |-> rdata[6:4] == 3'b000);
    // R3
    recover_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_recover && !(wr_ctrl && wdata[B_EN] && wdata[B_STOP] && !eng_is_master) |=> !slave_recover);
endmodule

// File: tb/tb_twb_csr.sv
// Bench: behavioural reference model stepped on each rising edge, compared on each falling edge.
module tb_twb_csr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 0, wr_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [4:0] eng_status = 5'h1F;
    logic eng_is_master = 1, eng_stop_done = 0, eng_flag_set = 0, glb_irq_en = 0;
    logic stop_req, if_enable, slave_recover, irq;
    logic [7:0] data_out;
    logic [6:0] prescale_div;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    twb_csr dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .eng_status(eng_status),
        .eng_is_master(eng_is_master), .eng_stop_done(eng_stop_done),
        .eng_flag_set(eng_flag_set), .glb_irq_en(glb_irq_en),
        .stop_req(stop_req), .if_enable(if_enable), .slave_recover(slave_recover),
        .irq(irq), .data_out(data_out), .prescale_div(prescale_div)
    );

    // reference model state
    bit m_en, m_ie, m_stop, m_flag, m_coll, m_rec;
    bit [7:0] m_data;
    bit [4:0] m_code;
    int m_ps;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_stop = 0; m_flag = 0; m_coll = 0; m_rec = 0;
            m_data = 0; m_code = 5'h1F; m_ps = 0;
            started = 1;
        end else begin
            bit cw, sw, dw, ask, old_flag;
            cw = wr_en && addr == 0;
            sw = wr_en && addr == 1;
            dw = wr_en && addr == 2;
            ask = cw && wdata[0] && wdata[2];
            old_flag = m_flag;
            m_rec = ask && !eng_is_master;
            if (cw && !wdata[0]) m_stop = 0;
            else if (ask && eng_is_master) m_stop = 1;
            else if (eng_stop_done) m_stop = 0;
            if (cw) begin m_en = wdata[0]; m_ie = wdata[1]; end
            if (eng_flag_set) m_flag = 1;
            else if (cw && wdata[7]) m_flag = 0;
            if (dw) begin
                if (old_flag) begin m_data = wdata; m_coll = 0; end
                else m_coll = 1;
            end
            if (sw) m_ps = int'(wdata[1:0]);
            m_code = eng_status;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output against the model in the middle of each cycle
    always @(negedge clk) begin
        if (started && rst_n && !finished) begin
            logic [7:0] exp_rd;
            case (addr)
                2'd0: exp_rd = {m_flag, 3'b000, m_coll, m_stop, m_ie, m_en};
                2'd1: exp_rd = {m_code, 1'b0, 2'(m_ps)};
                2'd2: exp_rd = m_data;
                default: exp_rd = 8'h00;
            endcase
            if (!rd_en) exp_rd = 8'h00;
            chk("R1 rdata", rdata, exp_rd);
            chk("R2 stop_req", {7'b0, stop_req}, {7'b0, m_stop});
            chk("R3 slave_recover", {7'b0, slave_recover}, {7'b0, m_rec});
            chk("R4 data_out", data_out, m_data);
            chk("R6 if_enable", {7'b0, if_enable}, {7'b0, m_en});
            chk("R7 irq", {7'b0, irq}, {7'b0, m_flag & m_ie & glb_irq_en});
            chk("R8 prescale_div", {1'b0, prescale_div}, 8'(1 << (2*m_ps)));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        rd_en = 1; addr = a;
        @(negedge clk);
        v = rdata;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic flag_event();
        @(posedge clk); #1 eng_flag_set = 1;
        @(posedge clk); #1 eng_flag_set = 0;
    endtask

    // watchdog
    initial begin
        #(5ns * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10 reset state
        rd(1, v); chk("R10 status reset", v, 8'hF8);
        rd(0, v); chk("R10 ctrl reset", v, 8'h00);
        chk("R10 divider reset", {1'b0, prescale_div}, 8'h01);

        // R9 / R8 status merge and prescaler write
        eng_status = 5'h08;
        wr(1, 8'hFF);
        rd(1, v); chk("R9 status merge", v, 8'h43);
        chk("R8 divide by 64", {1'b0, prescale_div}, 8'h40);
        wr(1, 8'h01);
        @(negedge clk); chk("R8 divide by 4", {1'b0, prescale_div}, 8'h04);

        // R2 master stop and auto clear
        eng_is_master = 1;
        wr(0, 8'h05);
        @(negedge clk); chk("R2 stop set", {7'b0, stop_req}, 8'h01);
        @(posedge clk); #1 eng_stop_done = 1;
        @(posedge clk); #1 eng_stop_done = 0;
        @(negedge clk); chk("R2 stop cleared", {7'b0, stop_req}, 8'h00);
        // R2 setting write wins over a same-cycle done
        @(posedge clk); #1 eng_stop_done = 1; wr_en = 1; addr = 0; wdata = 8'h05;
        @(posedge clk); #1 eng_stop_done = 0; wr_en = 0;
        @(negedge clk); chk("R2 set beats done", {7'b0, stop_req}, 8'h01);

        // R6 disable clears pending stop
        wr(0, 8'h04);
        @(negedge clk); chk("R6 disable stop", {6'b0, if_enable, stop_req}, 8'h00);

        // R3 slave recovery
        eng_is_master = 0;
        wr(0, 8'h05);
        @(negedge clk); chk("R3 recover pulse", {6'b0, slave_recover, stop_req}, 8'h02);
        @(negedge clk); chk("R3 recover ends", {7'b0, slave_recover}, 8'h00);

        // R5 collision with flag low
        wr(2, 8'hA5);
        rd(0, v); chk("R5 collision set", v & 8'h08, 8'h08);
        chk("R5 data kept", data_out, 8'h00);
        // R4 accepted write clears collision
        flag_event();
        wr(2, 8'h3C);
        rd(0, v); chk("R4 collision cleared", v & 8'h88, 8'h80);
        chk("R4 data stored", data_out, 8'h3C);
        // R7 irq and write-one-to-clear
        glb_irq_en = 1;
        wr(0, 8'h03);
        @(negedge clk); chk("R7 irq on", {7'b0, irq}, 8'h01);
        wr(0, 8'h83);
        @(negedge clk); chk("R7 flag cleared", {7'b0, irq}, 8'h00);
        // R5 write in the flag-set cycle is a collision; R7 event beats clear
        @(posedge clk); #1 eng_flag_set = 1; wr_en = 1; addr = 2; wdata = 8'h77;
        @(posedge clk); #1 eng_flag_set = 0; wr_en = 0;
        rd(0, v); chk("R5 same-cycle collision", v & 8'h88, 8'h88);
        chk("R5 data unchanged", data_out, 8'h3C);
        @(posedge clk); #1 eng_flag_set = 1; wr_en = 1; addr = 0; wdata = 8'h83;
        @(posedge clk); #1 eng_flag_set = 0; wr_en = 0;
        @(negedge clk); chk("R7 event beats clear", {7'b0, irq}, 8'h01);

        // R11 spare control bits
        wr(0, 8'h7B);
        rd(0, v); chk("R11 spare bits", v & 8'h78, 8'h08);

        // mixed traffic checked by the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_en = lfsr[0];
            wr_en = lfsr[1] & lfsr[2];
            addr = lfsr[4:3];
            wdata = lfsr[12:5];
            eng_status = lfsr[15:11];
            eng_is_master = lfsr[6];
            eng_stop_done = lfsr[7] & lfsr[9];
            eng_flag_set = lfsr[8] & lfsr[10] & lfsr[11];
            glb_irq_en = lfsr[13] | lfsr[14];
        end
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; eng_stop_done = 0; eng_flag_set = 0;
        @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule